// File: doc/BRIEF.md
# Pixel Bus Capture with Endian Select

This block takes 32-bit words from a frame-buffer pixel bus and turns each one into a stream of pixels for a display pipeline. It runs on the pixel clock. Word arrival is signalled by one of two capture strobes: a shift strobe in normal mode or a pass-through strobe in pass-through mode. Both are treated as clock enables that are already aligned to the pixel clock. In normal mode a captured word is cut into `BUS_W/PIX_W` channels. These channels are emitted one per pixel clock, least significant channel first. In pass-through mode each capture yields a single pixel, taken from the least significant channel.

One format bit in an 8-bit general control byte selects channel ordering. Bit 6 low selects little-endian. Bit 6 high selects big-endian, which reverses the whole bus bit by bit before it is split. This lets a bus wired in reverse order still deliver its first displayed pixel from the least significant channel. The format bit is sampled only when a word is captured, so a single word is never split with mixed ordering.

The controller is a three-state machine. `ST_IDLE` means no word is held. `ST_SHIFT` means a normal-mode word is being emitted, with a channel index stepping from 0 to the last channel. `ST_PASS` means a single pass-through pixel is shown for one cycle. The transitions are as follows:
- IDLE to SHIFT on a normal capture, and IDLE to PASS on a pass-through capture.
- SHIFT to SHIFT with the index incremented while the index is below the last channel.
- From the last SHIFT cycle or from PASS: to SHIFT on a normal capture, to PASS on a pass-through capture, and otherwise back to IDLE.

Top module: `pixbus_capture`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it, `pix_vld` is 0, `pix_out` is 0 and the machine is in `ST_IDLE`.
- R2: With `pass_mode`=0, a high `word_stb` at a rising clock captures `bus_word`. Channel 0 appears on `pix_out` with `pix_vld`=1 after that edge. The remaining channels follow on consecutive clocks, one per clock. `pix_vld` drops after the last channel if no new capture occurs.
- R3: With `gen_ctrl[6]`=0 at capture (little-endian), pixel k is `bus_word[k*PIX_W +: PIX_W]`.
- R4: With `gen_ctrl[6]`=1 at capture (big-endian), the bus is reversed so that bus bit i lands at position `BUS_W-1-i`. Pixel k is then bits `[k*PIX_W +: PIX_W]` of the reversed word.
- R5: `gen_ctrl[6]` is sampled only at capture. Changing it while a word is being emitted does not alter that word's pixels.
- R6: `gen_ctrl` bits other than bit 6 have no effect on the emitted pixels.
- R7: A `word_stb` that arrives while any channel other than the last is being shown is ignored. The current word completes unchanged, and no extra word follows.
- R8: A `word_stb` at the edge that ends the last channel captures the next word, with no idle cycle between the two words.
- R9: With `pass_mode`=1, a high `pt_stb` captures `bus_word`. Exactly one pixel is emitted: channel 0 of the ordered word, with `pix_vld` high for one cycle.
- R10: `word_stb` is ignored when `pass_mode`=1, and `pt_stb` is ignored when `pass_mode`=0. An ignored strobe leaves `pix_vld` at 0.
- R11: `pix_out` is 0 whenever `pix_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_word | input | BUS_W | Frame-buffer pixel bus word |
| word_stb | input | 1 | Normal-mode capture strobe (shift clock enable) |
| pt_stb | input | 1 | Pass-through capture strobe |
| pass_mode | input | 1 | 1 selects pass-through mode |
| gen_ctrl | input | 8 | General control byte; bit 6 selects big-endian |
| pix_out | output | PIX_W | Current pixel |
| pix_vld | output | 1 | Pixel valid |

## Verification
Two events can fall in the same cycle: the last channel of one word is shown while the capture strobe for the next word is high, so the same edge ends one word and loads the next. The bench provokes this by raising the strobe on the cycle where channel 3 is visible. It then judges the result by requiring channel 0 of the new word on the very next cycle, with `pix_vld` never low in between. A related coincidence is a strobe or a format-bit change during a non-last channel. The bench requires these to leave the running word untouched and to add no trailing word.

// File: rtl/pbc_pkg.sv
package pbc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_PASS  = 2'd2
    } pbc_state_t;

    // Position of the format bit in the general control byte
    localparam int FMT_BIT = 6;
endpackage

// File: rtl/pbc_bit_order.sv
module pbc_bit_order #(
    parameter int W = 32
) (
    input  logic [W-1:0] din,
    input  logic         reverse,
    output logic [W-1:0] dout
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign dout[i] = reverse ? din[W-1-i] : din[i];
    end
endmodule

// File: rtl/pbc_lane_sel.sv
module pbc_lane_sel #(
    parameter int W    = 32,
    parameter int PW   = 8,
    localparam int N   = W / PW,
    localparam int IW  = (N > 1) ? $clog2(N) : 1
) (
    input  logic [W-1:0]  word,
    input  logic [IW-1:0] sel,
    output logic [PW-1:0] lane
);
    logic [PW-1:0] lanes [N];

    for (genvar k = 0; k < N; k++) begin : g_lane
        assign lanes[k] = word[k*PW +: PW];
    end

    assign lane = lanes[sel];
endmodule

// File: rtl/pixbus_capture.sv
module pixbus_capture #(
    parameter int BUS_W = 32,
    parameter int PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BUS_W-1:0] bus_word,
    input  logic             word_stb,
    input  logic             pt_stb,
    input  logic             pass_mode,
    input  logic [7:0]       gen_ctrl,
    output logic [PIX_W-1:0] pix_out,
    output logic             pix_vld
);
    import pbc_pkg::*;

    localparam int NPIX  = BUS_W / PIX_W;
    localparam int IDX_W = (NPIX > 1) ? $clog2(NPIX) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NPIX - 1);

    pbc_state_t       state, next_state;
    logic [IDX_W-1:0] idx;
    logic [BUS_W-1:0] word_q;
    logic [BUS_W-1:0] ordered;
    logic [PIX_W-1:0] lane;
    logic             cap_norm, cap_pt, word_done;
    logic             ctrl_unused;

    assign ctrl_unused = ^gen_ctrl;
    assign cap_norm    = !pass_mode && word_stb;
    assign cap_pt      = pass_mode && pt_stb;
    assign word_done   = (state != ST_SHIFT) || (idx == LAST);

    pbc_bit_order #(.W(BUS_W)) u_order (
        .din     (bus_word),
        .reverse (gen_ctrl[FMT_BIT]),
        .dout    (ordered)
    );

    pbc_lane_sel #(.W(BUS_W), .PW(PIX_W)) u_lane (
        .word (word_q),
        .sel  (idx),
        .lane (lane)
    );

    // Next-state decision
    always_comb begin
        next_state = state;
        unique case (state)
            ST_IDLE, ST_PASS: begin
                if (cap_norm)    next_state = ST_SHIFT;
                else if (cap_pt) next_state = ST_PASS;
                else             next_state = ST_IDLE;
            end
            ST_SHIFT: begin
                if (idx != LAST) next_state = ST_SHIFT;
                else if (cap_norm) next_state = ST_SHIFT;
                else if (cap_pt)   next_state = ST_PASS;
                else               next_state = ST_IDLE;
            end
            default: next_state = ST_IDLE;
        endcase
    end

    // State register, channel index and held word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            idx    <= '0;
            word_q <= '0;
        end else begin
            state <= next_state;
            if (word_done) begin
                idx <= '0;
                if (cap_norm || cap_pt) begin
                    word_q <= ordered;   // format fixed for the whole word
                end
            end else begin
                idx <= idx + IDX_W'(1);
            end
        end
    end

    // Outputs
    always_comb begin
        pix_vld = 1'b0;
        pix_out = '0;
        unique case (state)
            ST_SHIFT, ST_PASS: begin
                pix_vld = 1'b1;
                pix_out = lane;
            end
            ST_IDLE: begin
                pix_vld = 1'b0;
                pix_out = '0;
            end
            default: begin
                pix_vld = 1'b0;
                pix_out = '0;
            end
        endcase
    end
endmodule

// File: rtl/pixbus_capture_chk.sv
module pixbus_capture_chk #(
    parameter int BUS_W = 32,
    parameter int IDX_W = 2,
    parameter logic [IDX_W-1:0] LAST = '1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               word_stb,
    input logic               pt_stb,
    input logic               pass_mode,
    input logic               pix_vld,
    input pbc_pkg::pbc_state_t state,
    input logic [IDX_W-1:0]   idx,
    input logic [BUS_W-1:0]   word_q
);
    import pbc_pkg::*;

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (state == ST_IDLE && !pix_vld));

    assert_first_pixel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !pass_mode && word_stb) |=> (state == ST_SHIFT && idx == '0 && pix_vld));

    assert_index_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && idx != LAST) |=> (state == ST_SHIFT && idx == IDX_W'($past(idx) + 1'b1)));

    assert_word_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && idx != LAST) |=> $stable(word_q));

    assert_chain_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && idx == LAST && !pass_mode && word_stb) |=> (state == ST_SHIFT && idx == '0));

    assert_pass_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PASS && !(pass_mode && pt_stb) && !(!pass_mode && word_stb)) |=> !pix_vld);

    assert_ignore_pt_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !pass_mode && !word_stb) |=> !pix_vld);

    assert_ignore_word_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && pass_mode && !pt_stb) |=> !pix_vld);
endmodule

bind pixbus_capture pixbus_capture_chk #(
    .BUS_W (BUS_W),
    .IDX_W (IDX_W),
    .LAST  (LAST)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .word_stb  (word_stb),
    .pt_stb    (pt_stb),
    .pass_mode (pass_mode),
    .pix_vld   (pix_vld),
    .state     (state),
    .idx       (idx),
    .word_q    (word_q)
);

// File: tb/pixbus_capture_test.sv
module pixbus_capture_test;
    localparam int CLK_PERIOD = 10;
    localparam int BUS_W = 32;
    localparam int PIX_W = 8;
    localparam int NPIX  = BUS_W / PIX_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [BUS_W-1:0] bus_word = '0;
    logic             word_stb = 1'b0;
    logic             pt_stb = 1'b0;
    logic             pass_mode = 1'b0;
    logic [7:0]       gen_ctrl = 8'h00;
    logic [PIX_W-1:0] pix_out;
    logic             pix_vld;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pixbus_capture #(.BUS_W(BUS_W), .PIX_W(PIX_W)) uut (
        .clk(clk), .rst_n(rst_n), .bus_word(bus_word), .word_stb(word_stb),
        .pt_stb(pt_stb), .pass_mode(pass_mode), .gen_ctrl(gen_ctrl),
        .pix_out(pix_out), .pix_vld(pix_vld)
    );

    function automatic logic [PIX_W-1:0] exp_pix(input logic [BUS_W-1:0] w, input bit be, input int k);
        logic [BUS_W-1:0] r;
        for (int i = 0; i < BUS_W; i++) r[i] = be ? w[BUS_W-1-i] : w[i];
        return r[k*PIX_W +: PIX_W];
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Capture one normal-mode word and check all of its pixels.
    // flip: toggle the format bit right after capture (R5)
    // mid:  raise word_stb during channel 1 (R7)
    task automatic play_word(input logic [BUS_W-1:0] w, input logic [7:0] ctrl,
                             input bit flip, input bit mid, input string tag);
        bit be;
        be = ctrl[6];
        @(negedge clk);
        bus_word = w; gen_ctrl = ctrl; word_stb = 1'b1;
        @(negedge clk);
        word_stb = 1'b0; bus_word = ~w;
        if (flip) gen_ctrl = ctrl ^ 8'h40;
        for (int k = 0; k < NPIX; k++) begin
            if (k > 0) @(negedge clk);
            if (k == 2) word_stb = 1'b0;
            check({tag, " vld"}, 32'(pix_vld), 32'd1);
            check({tag, " pix"}, 32'(pix_out), 32'(exp_pix(w, be, k)));
            if (mid && k == 1) word_stb = 1'b1;
        end
        @(negedge clk);
        check({tag, " end vld R2"}, 32'(pix_vld), 32'd0);
        check({tag, " idle pix R11"}, 32'(pix_out), 32'd0);
    endtask

    initial begin
        logic [BUS_W-1:0] w1, w2;
        repeat (3) @(negedge clk);
        check("R1 reset vld", 32'(pix_vld), 32'd0);
        check("R1 reset pix", 32'(pix_out), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset vld", 32'(pix_vld), 32'd0);

        // Walking-one sweep over every bus bit, both formats (R3, R4)
        for (int be = 0; be < 2; be++) begin
            for (int i = 0; i < BUS_W; i++) begin
                play_word(32'h1 << i, be ? 8'h40 : 8'h00, 1'b0, 1'b0, be ? "R4 walk" : "R3 walk");
            end
        end
        // Mixed patterns computed arithmetically
        for (int i = 0; i < 8; i++) begin
            play_word(32'(i + 1) * 32'h9E3779B1, 8'h00, 1'b0, 1'b0, "R3 mix");
            play_word(32'(i + 1) * 32'h7F4A7C15, 8'h40, 1'b0, 1'b0, "R4 mix");
        end

        // R6: other control bits have no effect
        play_word(32'h12345678, 8'hBF, 1'b0, 1'b0, "R6 little");
        play_word(32'h12345678, 8'hFF, 1'b0, 1'b0, "R6 big");

        // R5: format change during a word
        play_word(32'hA5C3F00F, 8'h40, 1'b1, 1'b0, "R5 be->le");
        play_word(32'h0F1E2D3C, 8'h00, 1'b1, 1'b0, "R5 le->be");

        // R7: strobe during a non-last channel
        play_word(32'hDEADBEEF, 8'h00, 1'b0, 1'b1, "R7 mid strobe");
        play_word(32'hCAFEF00D, 8'h40, 1'b0, 1'b1, "R7 mid strobe be");

        // R8: back-to-back words, capture on the last-channel cycle
        w1 = 32'h11223344; w2 = 32'h8899AABB;
        @(negedge clk);
        bus_word = w1; gen_ctrl = 8'h00; word_stb = 1'b1;
        @(negedge clk);
        word_stb = 1'b0;
        for (int k = 0; k < NPIX; k++) begin
            if (k > 0) @(negedge clk);
            check("R8 first word", 32'(pix_out), 32'(exp_pix(w1, 1'b0, k)));
        end
        bus_word = w2; gen_ctrl = 8'h40; word_stb = 1'b1;
        @(negedge clk);
        word_stb = 1'b0;
        for (int k = 0; k < NPIX; k++) begin
            if (k > 0) @(negedge clk);
            check("R8 no gap vld", 32'(pix_vld), 32'd1);
            check("R8 second word", 32'(pix_out), 32'(exp_pix(w2, 1'b1, k)));
        end
        @(negedge clk);
        check("R8 end vld", 32'(pix_vld), 32'd0);

        // R9: pass-through single pixel, both formats
        pass_mode = 1'b1;
        for (int be = 0; be < 2; be++) begin
            for (int i = 0; i < 4; i++) begin
                w1 = 32'(i + 3) * 32'h01030507;
                @(negedge clk);
                bus_word = w1; gen_ctrl = be ? 8'h40 : 8'h00; pt_stb = 1'b1;
                @(negedge clk);
                pt_stb = 1'b0;
                check("R9 pass vld", 32'(pix_vld), 32'd1);
                check("R9 pass pix", 32'(pix_out), 32'(exp_pix(w1, be[0], 0)));
                @(negedge clk);
                check("R9 one cycle", 32'(pix_vld), 32'd0);
            end
        end

        // R10: strobe of the wrong mode is ignored
        @(negedge clk);
        bus_word = 32'hFFFFFFFF; word_stb = 1'b1;
        @(negedge clk);
        word_stb = 1'b0;
        check("R10 word_stb in pass mode", 32'(pix_vld), 32'd0);
        check("R10 word_stb pix R11", 32'(pix_out), 32'd0);
        @(negedge clk);
        check("R10 still idle", 32'(pix_vld), 32'd0);
        pass_mode = 1'b0;
        @(negedge clk);
        pt_stb = 1'b1;
        @(negedge clk);
        pt_stb = 1'b0;
        check("R10 pt_stb in normal mode", 32'(pix_vld), 32'd0);
        @(negedge clk);
        check("R10 still idle normal", 32'(pix_vld), 32'd0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R2 actual=hung expected=complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule